// File: doc/BRIEF.md
# Floating-Point Control and Status Word Unit

This block keeps the 32-bit control and status word of a floating-point unit. It serves reads and writes on a 5-bit control register number. Number 0 returns a fixed implementation and revision constant. Number 31 is the full word. Numbers 25, 26 and 28 are narrower views onto fields of that same word: the condition codes, the exception cause and flag fields, and the control settings.

An arithmetic unit reports each completed operation as a 6-bit exception vector. On every report the block replaces the cause field with that vector and ORs its five IEEE exception bits into the sticky flags. A trap is requested when an enabled cause is present, or when the unimplemented-operation cause is present.

The block also drives the rounding mode, the flush-to-zero control and the eight condition codes to the datapath. The trap request is a registered single-cycle pulse.

Top module: `fcsr_unit`

Word layout (bit positions):
- rounding mode: [1:0]
- flags: [6:2]
- enables: [11:7]
- cause: [17:12]
- reserved: [22:18]
- condition code 0: bit 23
- flush-to-zero: bit 24
- condition codes 1..7: [31:25]

Exception bit order, used by the flags, the enables, the cause field and the `op_exc` input:
- 0: inexact
- 1: underflow
- 2: overflow
- 3: divide-by-zero
- 4: invalid
- 5: unimplemented (cause field and `op_exc` only)

## Requirements
- R1: After synchronous reset the whole word is zero, and `fp_trap`, `round_mode`, `flush_zero` and `cond_codes` are all zero.
- R2: Register 0 always reads the parameter `IMPL_REV`; a write to register 0 changes nothing.
- R3: Register 25 reads as {24'b0, cc7..cc1, cc0}, taking cc0 from word bit 23 and cc7..cc1 from word bits [31:25]. A write to it sets word bit 23 from value bit 0 and word bits [31:25] from value bits [7:1], keeps every other field, and drives `cond_codes` = value[7:0].
- R4: Register 26 reads the word masked to the cause [17:12] and flag [6:2] fields; a write to it replaces only those two fields.
- R5: Register 28 reads the enables at [11:7], the rounding mode at [1:0] and the flush-to-zero bit at bit 2, with all other bits zero. A write to it replaces those three fields, moving value bit 2 into word bit 24, and keeps the condition codes, cause and flags.
- R6: Register 31 reads and writes the whole word, except that bits [22:18] always read zero.
- R7: A write to register 26, 28 or 31 raises `fp_trap` for exactly the next cycle when the resulting word has (cause[4:0] AND enables) nonzero or cause bit 5 set. A write to register 25 or to any other number never raises it.
- R8: An operation report (`op_valid` high) loads the cause field with `op_exc` and ORs `op_exc[4:0]` into the flags. Cause bit 5 never reaches the flags.
- R9: An operation report raises `fp_trap` for exactly the next cycle when (`op_exc[4:0]` AND enables) is nonzero or `op_exc[5]` is set. An all-zero report clears the cause field and raises no trap.
- R10: When a register write and an operation report arrive in the same cycle, the write takes effect and the report is dropped.
- R11: `round_mode` equals word bits [1:0] and `flush_zero` equals word bit 24. The rounding encodings are 0 nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity.
- R12: Register numbers other than 0, 25, 26, 28 and 31 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_addr | input | 5 | Control register number for both read and write |
| cr_wr_en | input | 1 | Write strobe for the addressed register |
| cr_wdata | input | 32 | Write value |
| cr_rdata | output | 32 | Combinational read of the addressed register view |
| op_valid | input | 1 | An operation has completed and `op_exc` is valid |
| op_exc | input | 6 | Exception vector of that operation |
| fp_trap | output | 1 | One-cycle floating-point trap request |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| cond_codes | output | 8 | Condition codes 7..0 |

## Verification
The assertions assume the following about the block's inputs:
- the register number is stable within the cycle in which it is read;
- a trap can only follow a cycle in which a write or an operation report was presented;
- the datapath controls can only move after a register write.

The stimulus meets these assumptions by changing inputs only at the falling edge. Each strobe is held for exactly one cycle, followed by an idle cycle. That idle cycle lets every trap pulse be seen to end, and lets the read views be compared while nothing is being written.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int EXC_W   = 5;
    localparam int CAUSE_W = EXC_W + 1;
    localparam int CC_W    = 8;

    localparam logic [ADDR_W-1:0] CR_ID   = 5'd0;
    localparam logic [ADDR_W-1:0] CR_CC   = 5'd25;
    localparam logic [ADDR_W-1:0] CR_XC   = 5'd26;
    localparam logic [ADDR_W-1:0] CR_CTL  = 5'd28;
    localparam logic [ADDR_W-1:0] CR_FULL = 5'd31;

    localparam int CTL_FS_BIT = 2;
    localparam int UNIMPL_BIT = EXC_W;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic [CC_W-2:0]    fcc_hi;
        logic               fs;
        logic               fcc0;
        logic [4:0]         rsvd;
        logic [CAUSE_W-1:0] cause;
        logic [EXC_W-1:0]   enables;
        logic [EXC_W-1:0]   flags;
        rmode_e             rm;
    } fcsr_t;

    function automatic logic trap_due(input fcsr_t w);
        return ((w.cause[EXC_W-1:0] & w.enables) != '0) || w.cause[UNIMPL_BIT];
    endfunction

    function automatic logic [CC_W-1:0] cc_of(input fcsr_t w);
        return {w.fcc_hi, w.fcc0};
    endfunction

endpackage

// File: rtl/fcsr_read_view.sv
module fcsr_read_view
    import fcsr_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL_REV = 32'h0000_0A31
) (
    input  fcsr_t               csr,
    input  logic [ADDR_W-1:0]   addr,
    output logic [WORD_W-1:0]   rdata
);
    fcsr_t xc_view;
    fcsr_t ctl_view;
    logic [WORD_W-1:0] ctl_bits;

    always_comb begin
        xc_view       = '0;
        xc_view.cause = csr.cause;
        xc_view.flags = csr.flags;

        ctl_view         = '0;
        ctl_view.enables = csr.enables;
        ctl_view.rm      = csr.rm;
        ctl_bits         = WORD_W'(ctl_view);
        ctl_bits[CTL_FS_BIT] = csr.fs;
    end

    always_comb begin
        case (addr)
            CR_ID:   rdata = IMPL_REV;
            CR_CC:   rdata = {{(WORD_W-CC_W){1'b0}}, cc_of(csr)};
            CR_XC:   rdata = WORD_W'(xc_view);
            CR_CTL:  rdata = ctl_bits;
            CR_FULL: rdata = WORD_W'(csr);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcsr_write_merge.sv
module fcsr_write_merge
    import fcsr_pkg::*;
(
    input  fcsr_t               csr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output fcsr_t               merged,
    output logic                trap_view
);
    fcsr_t w;

    always_comb begin
        w         = fcsr_t'(wdata);
        merged    = csr;
        trap_view = 1'b0;
        case (addr)
            CR_CC: begin
                merged.fcc0   = wdata[0];
                merged.fcc_hi = wdata[CC_W-1:1];
            end
            CR_XC: begin
                merged.cause = w.cause;
                merged.flags = w.flags;
                trap_view    = 1'b1;
            end
            CR_CTL: begin
                merged.enables = w.enables;
                merged.rm      = w.rm;
                merged.fs      = wdata[CTL_FS_BIT];
                trap_view      = 1'b1;
            end
            CR_FULL: begin
                merged      = w;
                merged.rsvd = '0;
                trap_view   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fcsr_exc_merge.sv
module fcsr_exc_merge
    import fcsr_pkg::*;
(
    input  fcsr_t               csr,
    input  logic [CAUSE_W-1:0]  exc,
    output fcsr_t               merged
);
    always_comb begin
        merged       = csr;
        merged.cause = exc;
        merged.flags = csr.flags | exc[EXC_W-1:0];
    end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
#(
    parameter logic [31:0] IMPL_REV = 32'h0000_0A31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  cr_addr,
    input  logic        cr_wr_en,
    input  logic [31:0] cr_wdata,
    output logic [31:0] cr_rdata,
    input  logic        op_valid,
    input  logic [5:0]  op_exc,
    output logic        fp_trap,
    output logic [1:0]  round_mode,
    output logic        flush_zero,
    output logic [7:0]  cond_codes
);
    fcsr_t csr_q;
    fcsr_t csr_d;
    fcsr_t wr_word;
    fcsr_t op_word;
    logic  wr_traps;
    logic  trap_d;
    logic  trap_q;
    logic [EXC_W-1:0] flags_now;

    fcsr_read_view #(.IMPL_REV(IMPL_REV)) u_read (
        .csr   (csr_q),
        .addr  (cr_addr),
        .rdata (cr_rdata)
    );

    fcsr_write_merge u_write (
        .csr       (csr_q),
        .addr      (cr_addr),
        .wdata     (cr_wdata),
        .merged    (wr_word),
        .trap_view (wr_traps)
    );

    fcsr_exc_merge u_exc (
        .csr    (csr_q),
        .exc    (op_exc),
        .merged (op_word)
    );

    always_comb begin
        if (cr_wr_en) begin
            csr_d  = wr_word;
            trap_d = wr_traps && trap_due(wr_word);
        end else if (op_valid) begin
            csr_d  = op_word;
            trap_d = trap_due(op_word);
        end else begin
            csr_d  = csr_q;
            trap_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            csr_q  <= csr_d;
            trap_q <= trap_d;
        end
    end

    assign fp_trap    = trap_q;
    assign round_mode = csr_q.rm;
    assign flush_zero = csr_q.fs;
    assign cond_codes = cc_of(csr_q);
    assign flags_now  = csr_q.flags;
endmodule

// File: rtl/fcsr_unit_check.sv
module fcsr_unit_check #(
    parameter logic [31:0] IMPL_REV = 32'h0000_0A31
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  cr_addr,
    input logic        cr_wr_en,
    input logic        op_valid,
    input logic [5:0]  op_exc,
    input logic [31:0] cr_rdata,
    input logic        fp_trap,
    input logic [1:0]  round_mode,
    input logic        flush_zero,
    input logic [7:0]  cond_codes,
    input logic [4:0]  csr_flags
);
    assert_id_const_R2: assert property (@(posedge clk) disable iff (rst)
        (cr_addr == 5'd0) |-> (cr_rdata == IMPL_REV));

    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cr_addr == 5'd31) |-> (cr_rdata[22:18] == 5'b0));

    assert_trap_cause_R7: assert property (@(posedge clk) disable iff (rst)
        fp_trap |-> $past(cr_wr_en || op_valid));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !cr_wr_en) |=>
            ((csr_flags & $past(csr_flags)) == $past(csr_flags)));

    assert_unimpl_traps_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !cr_wr_en && op_exc[5]) |=> fp_trap);

    assert_ctl_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !cr_wr_en |=> ($stable(round_mode) && $stable(flush_zero) && $stable(cond_codes)));

    assert_unused_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !(cr_addr inside {5'd0, 5'd25, 5'd26, 5'd28, 5'd31}) |-> (cr_rdata == 32'b0));
endmodule

bind fcsr_unit fcsr_unit_check #(.IMPL_REV(IMPL_REV)) u_check (
    .clk        (clk),
    .rst        (rst),
    .cr_addr    (cr_addr),
    .cr_wr_en   (cr_wr_en),
    .op_valid   (op_valid),
    .op_exc     (op_exc),
    .cr_rdata   (cr_rdata),
    .fp_trap    (fp_trap),
    .round_mode (round_mode),
    .flush_zero (flush_zero),
    .cond_codes (cond_codes),
    .csr_flags  (flags_now)
);

// File: tb/fcsr_unit_test.sv
module fcsr_unit_test;
    localparam logic [31:0] IMPL = 32'h0000_0A31;
    localparam logic [31:0] M_XC  = 32'h0003_F07C;
    localparam logic [31:0] M_CTL = 32'h0000_0F83;
    localparam logic [31:0] M_CC  = 32'hFE80_0000;
    localparam logic [31:0] M_RSV = 32'h007C_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cr_addr = '0;
    logic        cr_wr_en = 1'b0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        op_valid = 1'b0;
    logic [5:0]  op_exc = '0;
    logic        fp_trap;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic [7:0]  cond_codes;

    int checks = 0;
    int failures = 0;
    logic [31:0] model = '0;

    fcsr_unit #(.IMPL_REV(IMPL)) uut (
        .clk(clk), .rst(rst), .cr_addr(cr_addr), .cr_wr_en(cr_wr_en),
        .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .op_valid(op_valid),
        .op_exc(op_exc), .fp_trap(fp_trap), .round_mode(round_mode),
        .flush_zero(flush_zero), .cond_codes(cond_codes)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] m_write(input logic [31:0] w, input logic [4:0] a,
                                            input logic [31:0] v);
        logic [31:0] r;
        r = w;
        case (a)
            5'd25: r = (w & ~M_CC) | ({25'b0, v[7:1]} << 25) | ({31'b0, v[0]} << 23);
            5'd26: r = (w & ~M_XC) | (v & M_XC);
            5'd28: r = (w & ~(M_CTL | 32'h0100_0000)) | (v & M_CTL) | ({31'b0, v[2]} << 24);
            5'd31: r = v & ~M_RSV;
            default: r = w;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] w, input logic [4:0] a);
        case (a)
            5'd0:  return IMPL;
            5'd25: return {24'b0, w[31:25], w[23]};
            5'd26: return w & M_XC;
            5'd28: return (w & M_CTL) | ({31'b0, w[24]} << 2);
            5'd31: return w;
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic m_trap(input logic [31:0] w);
        return ((w[16:12] & w[11:7]) != 5'b0) || w[17];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        cr_addr = a;
        #1;
        chk(tag, cr_rdata, m_read(model, a));
    endtask

    // one strobe cycle, then trap checked high/low and its end checked
    task automatic strobe(input string tag, input logic wr, input logic [4:0] a,
                          input logic [31:0] v, input logic op, input logic [5:0] s);
        logic exp_t;
        @(negedge clk);
        cr_wr_en = wr; cr_addr = a; cr_wdata = v; op_valid = op; op_exc = s;
        if (wr) begin
            model = m_write(model, a, v);
            exp_t = (a inside {5'd26, 5'd28, 5'd31}) && m_trap(model);
        end else begin
            model[17:12] = s;
            model[6:2]   = model[6:2] | s[4:0];
            exp_t = m_trap(model);
        end
        @(negedge clk);
        cr_wr_en = 1'b0; op_valid = 1'b0;
        chk({tag, " trap"}, {31'b0, fp_trap}, {31'b0, exp_t});
        @(negedge clk);
        chk({tag, " trap pulse end"}, {31'b0, fp_trap}, 32'b0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 word", 5'd31);
        chk("R1 outputs", {24'b0, cond_codes}, 32'b0);
        chk("R1 trap rm fs", {29'b0, fp_trap, round_mode}, {31'b0, flush_zero});
        // R2 constant, write ignored
        rd("R2 id", 5'd0);
        strobe("R2 write", 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0, 6'd0);
        rd("R2 id after", 5'd0);
        rd("R2 word kept", 5'd31);
        // R12 unused numbers
        rd("R12 read", 5'd5);
        strobe("R12 write", 1'b1, 5'd7, 32'hFFFF_FFFF, 1'b0, 6'd0);
        rd("R12 word kept", 5'd31);
        rd("R12 read 30", 5'd30);
        // R3 full sweep of condition code view
        for (int v = 0; v < 256; v++) begin
            strobe("R3 write", 1'b1, 5'd25, {24'hABCDEF, v[7:0]}, 1'b0, 6'd0);
            rd("R3 read25", 5'd25);
            rd("R3 word", 5'd31);
            chk("R3 cond_codes", {24'b0, cond_codes}, {24'b0, v[7:0]});
        end
        // R6 / R7 full-word writes
        begin
            logic [31:0] pats [5] = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
                                      32'h0002_0000, 32'h0000_0000};
            for (int i = 0; i < 5; i++) begin
                strobe("R6 R7 write31", 1'b1, 5'd31, pats[i], 1'b0, 6'd0);
                rd("R6 read31", 5'd31);
                rd("R4 read26", 5'd26);
                rd("R5 read28", 5'd28);
            end
        end
        // R7: a cause left pending, write 25 does not trap
        strobe("R7 prep", 1'b1, 5'd31, 32'h0001_1080, 1'b0, 6'd0);
        strobe("R7 write25 no trap", 1'b1, 5'd25, 32'h0000_0055, 1'b0, 6'd0);
        // R5 / R11 control view sweep
        for (int k = 0; k < 64; k++) begin
            strobe("R5 R7 write28", 1'b1, 5'd28, (k * 32'h0123_4567) ^ {26'b0, k[5:0]}, 1'b0, 6'd0);
            rd("R5 read28", 5'd28);
            rd("R5 word", 5'd31);
            chk("R11 round_mode", {30'b0, round_mode}, {30'b0, model[1:0]});
            chk("R11 flush_zero", {31'b0, flush_zero}, {31'b0, model[24]});
        end
        // R4 exception view
        for (int k = 0; k < 16; k++) begin
            strobe("R4 R7 write26", 1'b1, 5'd26, ~(k * 32'h1357_9BDF), 1'b0, 6'd0);
            rd("R4 read26", 5'd26);
            rd("R4 word", 5'd31);
        end
        // R8 / R9 operation report sweep under several enable masks
        begin
            logic [4:0] ens [3] = '{5'h00, 5'h1F, 5'h0A};
            for (int e = 0; e < 3; e++) begin
                strobe("R9 prep clear", 1'b1, 5'd26, 32'h0, 1'b0, 6'd0);
                strobe("R9 prep enables", 1'b1, 5'd28, {20'b0, ens[e], 7'b0}, 1'b0, 6'd0);
                for (int s = 0; s < 64; s++) begin
                    strobe("R8 R9 op", 1'b0, 5'd26, 32'h0, 1'b1, s[5:0]);
                    rd("R8 read26", 5'd26);
                end
                strobe("R9 zero op", 1'b0, 5'd26, 32'h0, 1'b1, 6'd0);
                rd("R9 cause cleared", 5'd26);
            end
        end
        // R10 write wins over simultaneous report
        strobe("R10 both", 1'b1, 5'd26, 32'h0000_0000, 1'b1, 6'h3F);
        rd("R10 read26", 5'd26);
        strobe("R10 both 28", 1'b1, 5'd28, 32'h0000_0003, 1'b1, 6'h21);
        rd("R10 read31", 5'd31);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule